// File: doc/BRIEF.md
# Embedded-Sync Video Byte Stream Decoder

This block takes an 8-bit component video byte stream clocked at twice the pixel rate. All timing information travels inside the stream as 4-byte reference codes. The decoder looks for these codes and checks their protection bits. It pulls out the field (F), vertical-blanking (V) and horizontal (H) flags. A code with H=1 ends active video, and a code with H=0 starts it.

Active bytes arrive as Cb, Y, Cr, Y. Each one is tagged with its component. Every four bytes form a co-sited pixel pair: Cb and Cr with the first Y, followed by the second Y. From the accepted codes the block rebuilds these level signals for downstream capture logic:
- horizontal active
- horizontal sync
- vertical active
- vertical sync
- field

The line length between consecutive end-of-active codes is measured and compared with the selected format. The 525-line format expects 1716 bytes and the 625-line format expects 1728 bytes.

The format is picked with a static select input. Within a line, all byte offsets count from the first byte (0xFF) of the end-of-active code. That byte is offset 0.

Top module: `vid_stream_decoder`

## Requirements
- R1: A reference code is recognised when bytes 0xFF, 0x00, 0x00 are followed by a byte with bit 7 set. In that byte, bit 6 is F, bit 5 is V and bit 4 is H, and H=1 marks end of active video.
- R2: The protection nibble of a code must equal {V^H, F^H, F^V, F^V^H} in bits 3..0. If it does not, the code is ignored for all timing and `code_err_o` is set and stays set until reset.
- R3: Each active byte appears on `act_data_o` with `act_valid_o` high one clock after it is presented. `act_comp_o` is 0 for Cb, 1 for the first Y, 2 for Cr and 3 for the second Y, counting from the first byte after a start code.
- R4: One clock after the fourth byte of each group, `pair_valid_o` pulses. At the same time `cb_o`, `y0_o`, `cr_o` and `y1_o` carry that group's four bytes.
- R5: `hactive_o` goes high with the first Cb and stays high for exactly 1440 byte clocks. It falls before the next code.
- R6: `vactive_o` becomes the inverse of V one clock after an accepted code.
- R7: `hsync_o` rises one clock after the byte at offset 32 (525-line mode, `fmt625_i`=0) or offset 24 (625-line mode) is presented. It stays high for 64 byte clocks.
- R8: `field_o` and `vsync_o` take the F and V of the latest accepted code, and change only in the cycle `hsync_o` rises.
- R9: One clock after an accepted end code, `line_err_o` pulses if a previous accepted end code exists and the byte distance between the two differs from 1716 (525) or 1728 (625).
- R10: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock (twice pixel rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt625_i | input | 1 | 0: 525-line timing, 1: 625-line timing |
| data_i | input | 8 | Incoming stream byte |
| act_data_o | output | 8 | Active byte, delayed one clock |
| act_comp_o | output | 2 | Component tag of act_data_o |
| act_valid_o | output | 1 | act_data_o holds an active byte |
| cb_o | output | 8 | Pair Cb |
| y0_o | output | 8 | Pair first luma |
| cr_o | output | 8 | Pair Cr |
| y1_o | output | 8 | Pair second luma |
| pair_valid_o | output | 1 | Pair outputs valid for one clock |
| hactive_o | output | 1 | Horizontal active |
| hsync_o | output | 1 | Regenerated horizontal sync |
| vactive_o | output | 1 | Vertical active |
| vsync_o | output | 1 | Regenerated vertical sync |
| field_o | output | 1 | Field identifier |
| line_err_o | output | 1 | Line-length mismatch pulse |
| code_err_o | output | 1 | Sticky bad-protection flag |

## Verification
Every result here is one register away from the byte that causes it, so the bench presents byte k of a line on the falling edge. It then reads the outputs just after the rising edge that follows, and compares them with values tied to that same k:
- active tags, pair data and hactive are due for active byte k itself;
- hsync is high for k in [offset, offset+64);
- field and vsync change exactly at k equal to the offset;
- line_err and vactive follow the code byte at k=3.

Full lines are swept in both formats. The sweep includes a long line, a format switch and a code with corrupt protection. For each of these, the expected line distance is computed arithmetically from the blanking lengths.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [1:0] {
    COMP_CB = 2'd0,
    COMP_Y0 = 2'd1,
    COMP_CR = 2'd2,
    COMP_Y1 = 2'd3
  } comp_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_flags_t;
endpackage

// File: rtl/vsd_trs_detect.sv
module vsd_trs_detect
  import vsd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  output logic          code_ok_o,
  output logic          code_bad_o,
  output trs_flags_t    flags_o
);
  logic [DW-1:0] h0_q, h1_q, h2_q;
  logic          preamble;
  logic [3:0]    prot_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h0_q <= '0;
      h1_q <= '0;
      h2_q <= '0;
    end else begin
      h0_q <= data_i;
      h1_q <= h0_q;
      h2_q <= h1_q;
    end
  end

  always_comb begin
    preamble  = (h2_q == '1) && (h1_q == '0) && (h0_q == '0) && data_i[DW-1];
    flags_o.f = data_i[DW-2];
    flags_o.v = data_i[DW-3];
    flags_o.h = data_i[DW-4];
    prot_exp  = {flags_o.v ^ flags_o.h, flags_o.f ^ flags_o.h,
                 flags_o.f ^ flags_o.v, flags_o.f ^ flags_o.v ^ flags_o.h};
    code_ok_o  = preamble && (data_i[DW-5 -: 4] == prot_exp);
    code_bad_o = preamble && (data_i[DW-5 -: 4] != prot_exp);
  end
endmodule

// File: rtl/vsd_active_split.sv
module vsd_active_split
  import vsd_pkg::*;
#(
  parameter int DW           = 8,
  parameter int ACTIVE_BYTES = 1440
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          sav_i,
  input  logic          eav_i,
  output logic [DW-1:0] act_data_o,
  output logic [1:0]    act_comp_o,
  output logic          act_valid_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] y0_o,
  output logic [DW-1:0] cr_o,
  output logic [DW-1:0] y1_o,
  output logic          pair_valid_o
);
  localparam int CNT_W = $clog2(ACTIVE_BYTES + 1);

  logic             run_q;
  logic [CNT_W-1:0] idx_q;
  logic [DW-1:0]    cb_h, y0_h, cr_h;
  logic [1:0]       phase;

  assign phase = idx_q[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (eav_i) begin
      run_q <= 1'b0;
    end else if (sav_i) begin
      run_q <= 1'b1;
      idx_q <= '0;
    end else if (run_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == CNT_W'(ACTIVE_BYTES - 1)) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_data_o   <= '0;
      act_comp_o   <= '0;
      act_valid_o  <= 1'b0;
      pair_valid_o <= 1'b0;
      cb_h <= '0; y0_h <= '0; cr_h <= '0;
      cb_o <= '0; y0_o <= '0; cr_o <= '0; y1_o <= '0;
    end else begin
      act_valid_o  <= run_q;
      act_data_o   <= data_i;
      act_comp_o   <= phase;
      pair_valid_o <= run_q && (phase == COMP_Y1);
      if (run_q) begin
        unique case (phase)
          COMP_CB: cb_h <= data_i;
          COMP_Y0: y0_h <= data_i;
          COMP_CR: cr_h <= data_i;
          default: begin
            cb_o <= cb_h;
            y0_o <= y0_h;
            cr_o <= cr_h;
            y1_o <= data_i;
          end
        endcase
      end
    end
  end

  // R4
  pair_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (act_valid_o && act_comp_o == COMP_Y1));

  // R5
  hact_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_valid_o) |-> act_comp_o == COMP_CB);
endmodule

// File: rtl/vsd_timing.sv
module vsd_timing
  import vsd_pkg::*;
#(
  parameter int LINE_525   = 1716,
  parameter int LINE_625   = 1728,
  parameter int HS_OFF_525 = 32,
  parameter int HS_OFF_625 = 24,
  parameter int HS_LEN     = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fmt625_i,
  input  logic       code_ok_i,
  input  logic       code_bad_i,
  input  trs_flags_t flags_i,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       field_o,
  output logic       vactive_o,
  output logic       line_err_o,
  output logic       code_err_o
);
  localparam int LINE_MAX = (LINE_625 > LINE_525) ? LINE_625 : LINE_525;
  localparam int POS_W    = $clog2(2 * LINE_MAX);
  localparam int CODE_LEN = 4;

  logic [POS_W-1:0] pos_q, line_len, hs_off, hs_end;
  logic             have_eav_q, f_lat_q, v_lat_q, eav_ok;

  assign eav_ok   = code_ok_i && flags_i.h;
  assign line_len = fmt625_i ? POS_W'(LINE_625) : POS_W'(LINE_525);
  assign hs_off   = fmt625_i ? POS_W'(HS_OFF_625) : POS_W'(HS_OFF_525);
  assign hs_end   = hs_off + POS_W'(HS_LEN);

  // pos_q: offset of the byte now on the input, from the first byte of the last end code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '1;
      have_eav_q <= 1'b0;
    end else if (eav_ok) begin
      pos_q      <= POS_W'(CODE_LEN);
      have_eav_q <= 1'b1;
    end else if (pos_q != '1) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_lat_q    <= 1'b0;
      v_lat_q    <= 1'b0;
      vactive_o  <= 1'b0;
      hsync_o    <= 1'b0;
      field_o    <= 1'b0;
      vsync_o    <= 1'b0;
      line_err_o <= 1'b0;
      code_err_o <= 1'b0;
    end else begin
      if (code_ok_i) begin
        f_lat_q   <= flags_i.f;
        v_lat_q   <= flags_i.v;
        vactive_o <= ~flags_i.v;
      end
      if (pos_q == hs_off) begin
        hsync_o <= 1'b1;
        field_o <= f_lat_q;
        vsync_o <= v_lat_q;
      end else if (pos_q == hs_end) begin
        hsync_o <= 1'b0;
      end
      line_err_o <= eav_ok && have_eav_q &&
                    ((pos_q - POS_W'(CODE_LEN - 1)) != line_len);
      if (code_bad_i) code_err_o <= 1'b1;
    end
  end

  // R9
  line_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_err_o |-> $past(eav_ok));

  // R2
  code_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o |=> code_err_o);

  // R8
  field_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_o) |-> $rose(hsync_o));

  // R6
  vact_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vactive_o) |-> $past(code_ok_i));
endmodule

// File: rtl/vid_stream_decoder.sv
module vid_stream_decoder
  import vsd_pkg::*;
#(
  parameter int DW           = 8,
  parameter int ACTIVE_BYTES = 1440,
  parameter int LINE_525     = 1716,
  parameter int LINE_625     = 1728,
  parameter int HS_OFF_525   = 32,
  parameter int HS_OFF_625   = 24,
  parameter int HS_LEN       = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fmt625_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] act_data_o,
  output logic [1:0]    act_comp_o,
  output logic          act_valid_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] y0_o,
  output logic [DW-1:0] cr_o,
  output logic [DW-1:0] y1_o,
  output logic          pair_valid_o,
  output logic          hactive_o,
  output logic          hsync_o,
  output logic          vactive_o,
  output logic          vsync_o,
  output logic          field_o,
  output logic          line_err_o,
  output logic          code_err_o
);
  logic       code_ok, code_bad;
  trs_flags_t flags;

  vsd_trs_detect #(.DW(DW)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .code_ok_o  (code_ok),
    .code_bad_o (code_bad),
    .flags_o    (flags)
  );

  vsd_active_split #(.DW(DW), .ACTIVE_BYTES(ACTIVE_BYTES)) u_split (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .data_i       (data_i),
    .sav_i        (code_ok && !flags.h),
    .eav_i        (code_ok && flags.h),
    .act_data_o   (act_data_o),
    .act_comp_o   (act_comp_o),
    .act_valid_o  (act_valid_o),
    .cb_o         (cb_o),
    .y0_o         (y0_o),
    .cr_o         (cr_o),
    .y1_o         (y1_o),
    .pair_valid_o (pair_valid_o)
  );

  assign hactive_o = act_valid_o;

  vsd_timing #(
    .LINE_525   (LINE_525),
    .LINE_625   (LINE_625),
    .HS_OFF_525 (HS_OFF_525),
    .HS_OFF_625 (HS_OFF_625),
    .HS_LEN     (HS_LEN)
  ) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt625_i   (fmt625_i),
    .code_ok_i  (code_ok),
    .code_bad_i (code_bad),
    .flags_i    (flags),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .field_o    (field_o),
    .vactive_o  (vactive_o),
    .line_err_o (line_err_o),
    .code_err_o (code_err_o)
  );
endmodule

// File: tb/vid_stream_decoder_bench.sv
`timescale 1ns/1ps
module vid_stream_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fmt625 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] act_data, cb, y0, cr, y1;
  logic [1:0] act_comp;
  logic act_valid, pair_valid, hactive, hsync, vactive, vsync, field, line_err, code_err;

  int errors = 0;
  int checks = 0;
  int line_no = 0;
  bit prev_f = 0, prev_v = 0;

  always #2 clk = ~clk;

  vid_stream_decoder u_vid_stream_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .fmt625_i(fmt625), .data_i(din),
    .act_data_o(act_data), .act_comp_o(act_comp), .act_valid_o(act_valid),
    .cb_o(cb), .y0_o(y0), .cr_o(cr), .y1_o(y1), .pair_valid_o(pair_valid),
    .hactive_o(hactive), .hsync_o(hsync), .vactive_o(vactive), .vsync_o(vsync),
    .field_o(field), .line_err_o(line_err), .code_err_o(code_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    din = b;
    @(posedge clk);
    #1;
  endtask

  // blank: bytes from end-code start through start-code end
  task automatic send_line(input int blank, input bit f, input bit v, input bit bad,
                           input int hs_off, input bit hs_exp, input int err_exp);
    int total = blank + 1440;
    int m_act = 0, m_pair = 0, m_hact = 0, m_hs = 0;
    logic [7:0] q [3];
    for (int k = 0; k < total; k++) begin
      logic [7:0] b;
      int a = k - blank;
      if (k < 3) b = (k == 0) ? 8'hFF : 8'h00;
      else if (k == 3) b = xy(f, v, 1'b1) ^ (bad ? 8'h01 : 8'h00);
      else if (k < blank - 4) b = (k % 2 != 0) ? 8'h10 : 8'h80;
      else if (k < blank - 1) b = (k == blank - 4) ? 8'hFF : 8'h00;
      else if (k == blank - 1) b = xy(f, v, 1'b0);
      else b = 8'(32 + ((a * 3 + line_no) % 200));
      put(b);
      if (k == 3) begin
        if (err_exp >= 0) chk(line_err == err_exp[0], "R9 line_err", line_err, err_exp);
        if (!bad) chk(vactive == !v, "R6 vactive", vactive, !v);
        else chk(code_err == 1'b1, "R2 code_err", code_err, 1);
      end
      if (k >= blank) begin
        if (!act_valid || act_data != b || int'(act_comp) != a % 4) m_act++;
        if (!hactive) m_hact++;
        if (a % 4 < 3) q[a % 4] = b;
        if (a % 4 == 3) begin
          if (!pair_valid || cb != q[0] || y0 != q[1] || cr != q[2] || y1 != b) m_pair++;
        end else if (pair_valid) m_pair++;
      end else begin
        if (act_valid || pair_valid) m_act++;
        if (hactive) m_hact++;
      end
      if (k >= 4) begin
        bit e = hs_exp && k >= hs_off && k < hs_off + 64;
        if (hsync != e) m_hs++;
      end
      if (k == hs_off - 1)
        chk(field == prev_f && vsync == prev_v, "R8 hold before edge", {field, vsync}, {prev_f, prev_v});
      if (k == hs_off) begin
        if (hs_exp) begin
          chk(field == f && vsync == v, "R1 R8 flags at edge", {field, vsync}, {f, v});
          prev_f = f; prev_v = v;
        end else begin
          chk(field == prev_f && vsync == prev_v, "R2 ignored code", {field, vsync}, {prev_f, prev_v});
        end
      end
    end
    chk(m_act == 0, "R3 active tags", m_act, 0);
    chk(m_pair == 0, "R4 pairs", m_pair, 0);
    chk(m_hact == 0, "R5 hactive", m_hact, 0);
    chk(m_hs == 0, "R7 hsync", m_hs, 0);
    line_no++;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10
    chk({act_valid, pair_valid, hactive, hsync, vactive, vsync, field, line_err, code_err} == '0,
        "R10 reset outputs", {act_valid, hsync, vactive, code_err}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    send_line(276, 0, 1, 0, 32, 1, -1);
    send_line(276, 0, 0, 0, 32, 1, 0);
    send_line(276, 1, 0, 0, 32, 1, 0);
    send_line(280, 0, 0, 0, 32, 1, 0);
    send_line(276, 0, 0, 0, 32, 1, 1);
    send_line(276, 1, 1, 0, 32, 1, 0);
    @(negedge clk);
    fmt625 = 1'b1;
    send_line(288, 1, 1, 0, 24, 1, 1);
    send_line(288, 0, 0, 0, 24, 1, 0);
    send_line(288, 1, 1, 1, 24, 0, 0);
    send_line(288, 0, 0, 0, 24, 1, 1);
    chk(code_err == 1'b1, "R2 sticky", code_err, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule